// File: doc/BRIEF.md
# Autoincrement Change Recorder

This block keeps a 16-bit record of how the general registers were moved by autoincrement and autodecrement operand specifiers during the current instruction. Each time a specifier commits, the block receives the register number, the operand size and the direction. From these it works out the signed change and stores it as a one-byte entry. Two such entries fit in the word, so two different registers can be tracked per instruction. When an instruction aborts, software reads the word and uses it to undo the register changes before it restarts the instruction.

The record is cleared at the start of every instruction and at the start of a trap sequence. A freeze input holds the record unchanged while fault information is being preserved. A model-select input sets how the word looks when it is read. A machine without full memory management always reads zero. A full machine reads the raw word. A variant machine removes entries that only describe immediate-operand fetches (register 7 advanced by 2) before it returns the value. The read is combinational and never alters the stored record.

Top module: `arc_recorder`

## Requirements
- R1: After reset the stored record is zero, and a read under model code 1 returns 16'h0000.
- R2: An entry is one byte: bits 7:3 hold the change as a 5-bit two's-complement number and bits 2:0 hold the register number. specDec=0 means increment and specDec=1 means decrement. specSize codes 1, 2 and 3 give magnitudes of 2, 4 and 8. A word push on register 6 therefore records 8'o366.
- R3: With specSize code 0 (byte), registers 0 to 5 change by 1, while registers 6 and 7 change by 2.
- R4: Register 7 is recorded like any other register. An increment of register 7 with size code 2 or 3 (an immediate operand) records +2. A decrement of register 7 keeps the full size.
- R5: The first change of an instruction goes into the low byte. A change to a different register goes into the high byte. A change to a register that already has an entry adds to that entry's delta, modulo 32. A change to a third register is dropped. An unused byte reads as zero.
- R6: instStart clears the record unless freeze is high. A specifier committed in the same cycle is stored as the only entry, in the low byte.
- R7: trapStart clears the record unless freeze is high. It overrides a specifier or instStart in the same cycle.
- R8: While freeze is high, specifier commits, instStart and trapStart have no effect, and the record holds its value.
- R9: Model code 0 (no full memory management) makes every read return zero.
- R10: Model codes 1 and 3 return the stored record unchanged.
- R11: Model code 2 (variant) applies two steps in order. First, if the high byte equals 8'o027, it is cleared. Then, if the low byte equals 8'o027, the word is shifted right by 8.
- R12: rdData is valid in the same cycle that rdEn is high, and reads 0 while rdEn is low. Reading never changes the stored record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| specValid | input | 1 | A specifier register change commits this cycle |
| specReg | input | 3 | Register number of the change |
| specSize | input | 2 | Operand size code: 0 byte, 1 word, 2 four bytes, 3 eight bytes |
| specDec | input | 1 | 1 = decrement, 0 = increment |
| instStart | input | 1 | Instruction start clear |
| trapStart | input | 1 | Trap sequence start clear |
| freeze | input | 1 | Hold the record; ignore all updates |
| modelSel | input | 2 | Read presentation: 0 basic, 1 full, 2 variant, 3 full |
| rdEn | input | 1 | Bus read of the record |
| rdData | output | 16 | Presented record, combinational |

## Verification
Three pairs of events can land in the same cycle: a specifier commit with instStart, a specifier commit with trapStart, and any update with freeze. The bench drives each pair on a single clock edge. Afterwards it reads the word under model 1 and checks three outcomes. A commit that arrives with instStart must be the only entry left. A commit that arrives with trapStart must leave the word zero. Freeze must leave a record it has already loaded bit-for-bit intact. A read on the variant model is then followed by a read on the full model, which shows that the scrub did not alter the stored word.

// File: rtl/arc_pkg.sv
package arc_pkg;
  localparam int REG_W   = 3;
  localparam int DELTA_W = 5;
  localparam int ENTRY_W = DELTA_W + REG_W;
  localparam int LANES   = 2;
  localparam int WORD_W  = ENTRY_W * LANES;
  localparam int SIZE_W  = 2;
  localparam int MODEL_W = 2;

  localparam logic [REG_W-1:0] SP_REG = REG_W'(6);
  localparam logic [REG_W-1:0] PC_REG = REG_W'(7);
  // immediate fetch: PC advanced by 2
  localparam logic [ENTRY_W-1:0] IMM_ENTRY = {DELTA_W'(2), PC_REG};

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_QUAD = 2'd2,
    SZ_OCT  = 2'd3
  } size_e;

  typedef enum logic [MODEL_W-1:0] {
    MODEL_BASIC = 2'd0,
    MODEL_FULL  = 2'd1,
    MODEL_JVAR  = 2'd2,
    MODEL_FULL2 = 2'd3
  } model_e;

  typedef struct packed {
    logic               clear;
    logic [LANES-1:0]   load;
    logic [LANES-1:0]   add;
    logic [DELTA_W-1:0] delta;
    logic [REG_W-1:0]   regNum;
  } strobe_t;
endpackage

// File: rtl/arc_ctrl.sv
module arc_ctrl
  import arc_pkg::*;
(
  input  logic                        specValid,
  input  logic [REG_W-1:0]            specReg,
  input  logic [SIZE_W-1:0]           specSize,
  input  logic                        specDec,
  input  logic                        instStart,
  input  logic                        trapStart,
  input  logic                        freeze,
  input  logic [LANES-1:0]            laneUsed,
  input  logic [LANES-1:0][REG_W-1:0] laneReg,
  output strobe_t                     strobes
);
  logic [DELTA_W-1:0] magnitude;
  logic [DELTA_W-1:0] signedDelta;
  logic [LANES-1:0]   effUsed;
  logic               wideImm;

  // immediate operand: PC increment never moves by more than a word
  assign wideImm = (specReg == PC_REG) && !specDec;

  always_comb begin
    case (size_e'(specSize))
      SZ_BYTE: magnitude = (specReg >= SP_REG) ? DELTA_W'(2) : DELTA_W'(1);
      SZ_WORD: magnitude = DELTA_W'(2);
      SZ_QUAD: magnitude = wideImm ? DELTA_W'(2) : DELTA_W'(4);
      default: magnitude = wideImm ? DELTA_W'(2) : DELTA_W'(8);
    endcase
  end

  assign signedDelta = specDec ? (~magnitude + DELTA_W'(1)) : magnitude;
  // lanes as seen after an instruction-start clear in the same cycle
  assign effUsed = instStart ? '0 : laneUsed;

  always_comb begin
    logic matched;
    logic placed;
    matched = 1'b0;
    placed  = 1'b0;
    strobes = '0;
    strobes.delta  = signedDelta;
    strobes.regNum = specReg;
    if (!freeze) begin
      if (trapStart) begin
        strobes.clear = 1'b1;
      end else begin
        strobes.clear = instStart;
        if (specValid) begin
          for (int i = 0; i < LANES; i++) begin
            if (!matched && effUsed[i] && (laneReg[i] == specReg)) begin
              strobes.add[i] = 1'b1;
              matched = 1'b1;
            end
          end
          if (!matched) begin
            for (int i = 0; i < LANES; i++) begin
              if (!placed && !effUsed[i]) begin
                strobes.load[i] = 1'b1;
                placed = 1'b1;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/arc_datapath.sv
module arc_datapath
  import arc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strobes,
  output logic [LANES-1:0]            laneUsed,
  output logic [LANES-1:0][REG_W-1:0] laneReg,
  output logic [WORD_W-1:0]           statusWord
);
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [DELTA_W-1:0] deltaQ;
    logic [REG_W-1:0]   regQ;
    logic               usedQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        deltaQ <= '0;
        regQ   <= '0;
        usedQ  <= 1'b0;
      end else if (strobes.load[g]) begin
        deltaQ <= strobes.delta;
        regQ   <= strobes.regNum;
        usedQ  <= 1'b1;
      end else if (strobes.add[g]) begin
        deltaQ <= deltaQ + strobes.delta;
      end else if (strobes.clear) begin
        deltaQ <= '0;
        regQ   <= '0;
        usedQ  <= 1'b0;
      end
    end

    assign laneUsed[g] = usedQ;
    assign laneReg[g]  = regQ;
    assign statusWord[g*ENTRY_W +: ENTRY_W] = {deltaQ, regQ};

    AST_EMPTY_LANE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      !usedQ |-> ({deltaQ, regQ} == '0)); // R5

    if (g > 0) begin : gOrder
      AST_LANE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
        usedQ |-> laneUsed[g-1]); // R5
    end
  end
endmodule

// File: rtl/arc_scrub.sv
module arc_scrub
  import arc_pkg::*;
(
  input  logic [WORD_W-1:0]  rawWord,
  input  logic [MODEL_W-1:0] modelSel,
  input  logic               rdEn,
  output logic [WORD_W-1:0]  rdData
);
  logic [WORD_W-1:0] shown;

  always_comb begin
    shown = rawWord;
    case (model_e'(modelSel))
      MODEL_BASIC: shown = '0;
      MODEL_JVAR: begin
        if (shown[WORD_W-1 -: ENTRY_W] == IMM_ENTRY)
          shown[WORD_W-1 -: ENTRY_W] = '0;
        if (shown[ENTRY_W-1:0] == IMM_ENTRY)
          shown = shown >> ENTRY_W;
      end
      default: shown = rawWord;
    endcase
  end

  assign rdData = rdEn ? shown : '0;
endmodule

// File: rtl/arc_recorder.sv
module arc_recorder
  import arc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               specValid,
  input  logic [REG_W-1:0]   specReg,
  input  logic [SIZE_W-1:0]  specSize,
  input  logic               specDec,
  input  logic               instStart,
  input  logic               trapStart,
  input  logic               freeze,
  input  logic [MODEL_W-1:0] modelSel,
  input  logic               rdEn,
  output logic [WORD_W-1:0]  rdData
);
  strobe_t                     strobes;
  logic [LANES-1:0]            laneUsed;
  logic [LANES-1:0][REG_W-1:0] laneReg;
  logic [WORD_W-1:0]           statusWord;

  arc_ctrl i_ctrl (
    .specValid (specValid),
    .specReg   (specReg),
    .specSize  (specSize),
    .specDec   (specDec),
    .instStart (instStart),
    .trapStart (trapStart),
    .freeze    (freeze),
    .laneUsed  (laneUsed),
    .laneReg   (laneReg),
    .strobes   (strobes)
  );

  arc_datapath i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .laneUsed   (laneUsed),
    .laneReg    (laneReg),
    .statusWord (statusWord)
  );

  arc_scrub i_scrub (
    .rawWord  (statusWord),
    .modelSel (modelSel),
    .rdEn     (rdEn),
    .rdData   (rdData)
  );

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    freeze |=> $stable(statusWord)); // R8
  AST_TRAP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (trapStart && !freeze) |=> (statusWord == '0)); // R7
  AST_INST_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (instStart && !trapStart && !freeze && !specValid) |=> (statusWord == '0)); // R6
  AST_BASIC_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (modelSel == MODEL_BASIC) |-> (rdData == '0)); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> (rdData == '0)); // R12
  AST_FULL_RAW: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && ((modelSel == MODEL_FULL) || (modelSel == MODEL_FULL2)))
      |-> (rdData == statusWord)); // R10
  AST_JVAR_NO_IMM: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (modelSel == MODEL_JVAR))
      |-> ((rdData[ENTRY_W-1:0] != IMM_ENTRY) &&
           (rdData[WORD_W-1 -: ENTRY_W] != IMM_ENTRY))); // R11
endmodule

// File: tb/test_arc_recorder.sv
module test_arc_recorder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        specValid = 1'b0;
  logic [2:0]  specReg = '0;
  logic [1:0]  specSize = '0;
  logic        specDec = 1'b0;
  logic        instStart = 1'b0;
  logic        trapStart = 1'b0;
  logic        freeze = 1'b0;
  logic [1:0]  modelSel = 2'd1;
  logic        rdEn = 1'b0;
  logic [15:0] rdData;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  arc_recorder i_arc_recorder (
    .clk(clk), .rstN(rstN), .specValid(specValid), .specReg(specReg),
    .specSize(specSize), .specDec(specDec), .instStart(instStart),
    .trapStart(trapStart), .freeze(freeze), .modelSel(modelSel),
    .rdEn(rdEn), .rdData(rdData)
  );

  function automatic logic [7:0] ent(input int r, input int d);
    logic [4:0] d5;
    d5 = 5'(d);
    return {d5, 3'(r)};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic readAs(input int model, output logic [15:0] v);
    modelSel = 2'(model);
    rdEn = 1'b1;
    #1;
    v = rdData;
    rdEn = 1'b0;
    modelSel = 2'd1;
  endtask

  task automatic readChk(input int model, input logic [15:0] exp, input string tag);
    logic [15:0] v;
    readAs(model, v);
    chk(tag, v, exp);
  endtask

  // one clock of stimulus, driven at the falling edge
  task automatic step(input bit sv, input int r, input int sz, input bit dec,
                      input bit inst, input bit trap, input bit frz);
    @(negedge clk);
    specValid = sv; specReg = 3'(r); specSize = 2'(sz); specDec = dec;
    instStart = inst; trapStart = trap; freeze = frz;
    @(negedge clk);
    specValid = 1'b0; instStart = 1'b0; trapStart = 1'b0; freeze = 1'b0;
  endtask

  task automatic spec(input int r, input int sz, input bit dec);
    step(1'b1, r, sz, dec, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic newInst();
    step(1'b0, 0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testReset();
    readChk(1, 16'h0000, "R1 reset record");
  endtask

  task automatic testFormatAndPacking();
    newInst();
    spec(2, 1, 1'b0);
    readChk(1, {8'h00, ent(2, 2)}, "R2 word increment entry");
    spec(2, 1, 1'b0);
    readChk(1, {8'h00, ent(2, 4)}, "R5 same register accumulates");
    spec(3, 3, 1'b1);
    readChk(1, {ent(3, -8), ent(2, 4)}, "R2 eight-byte decrement in high byte");
    spec(4, 1, 1'b0);
    readChk(1, {ent(3, -8), ent(2, 4)}, "R5 third register dropped");
    spec(3, 3, 1'b1);
    readChk(1, {ent(3, -16), ent(2, 4)}, "R5 high entry accumulates");
    newInst();
    spec(6, 1, 1'b1);
    readChk(1, 16'o366, "R2 stack push records 366");
  endtask

  task automatic testByteMode();
    newInst();
    spec(1, 0, 1'b0);
    spec(6, 0, 1'b1);
    readChk(1, {ent(6, -2), ent(1, 1)}, "R3 byte r1 +1, r6 -2");
    newInst();
    spec(7, 0, 1'b0);
    readChk(1, {8'h00, ent(7, 2)}, "R3 byte on PC moves by 2");
  endtask

  task automatic testPcAndImmediate();
    newInst();
    spec(7, 3, 1'b0);
    readChk(1, {8'h00, ent(7, 2)}, "R4 immediate eight-byte is +2");
    newInst();
    spec(7, 2, 1'b1);
    spec(0, 2, 1'b0);
    readChk(1, {ent(0, 4), ent(7, -4)}, "R4 PC decrement keeps size");
  endtask

  task automatic testInstClearCollision();
    newInst();
    spec(1, 1, 1'b0);
    spec(2, 1, 1'b0);
    step(1'b1, 5, 1, 1'b0, 1'b1, 1'b0, 1'b0);
    readChk(1, {8'h00, ent(5, 2)}, "R6 commit with instStart is sole entry");
    newInst();
    readChk(1, 16'h0000, "R6 instStart clears");
  endtask

  task automatic testTrap();
    newInst();
    spec(1, 1, 1'b0);
    step(1'b1, 3, 1, 1'b0, 1'b0, 1'b1, 1'b0);
    readChk(1, 16'h0000, "R7 trap beats same-cycle commit");
    spec(4, 1, 1'b0);
    step(1'b1, 5, 1, 1'b0, 1'b1, 1'b1, 1'b0);
    readChk(1, 16'h0000, "R7 trap beats instStart with commit");
  endtask

  task automatic testFreeze();
    newInst();
    spec(2, 1, 1'b0);
    step(1'b1, 3, 1, 1'b0, 1'b0, 1'b0, 1'b1);
    readChk(1, {8'h00, ent(2, 2)}, "R8 commit ignored while frozen");
    step(1'b1, 2, 1, 1'b0, 1'b0, 1'b0, 1'b1);
    readChk(1, {8'h00, ent(2, 2)}, "R8 accumulate ignored while frozen");
    step(1'b0, 0, 0, 1'b0, 1'b1, 1'b0, 1'b1);
    readChk(1, {8'h00, ent(2, 2)}, "R8 instStart ignored while frozen");
    step(1'b0, 0, 0, 1'b0, 1'b0, 1'b1, 1'b1);
    readChk(1, {8'h00, ent(2, 2)}, "R8 trap ignored while frozen");
  endtask

  task automatic testModels();
    newInst();
    spec(2, 1, 1'b0);
    spec(7, 1, 1'b0);
    readChk(0, 16'h0000, "R9 basic model reads zero");
    readChk(2, {8'h00, ent(2, 2)}, "R11 high immediate entry erased");
    readChk(3, {ent(7, 2), ent(2, 2)}, "R10 model 3 raw");
    readChk(1, {ent(7, 2), ent(2, 2)}, "R12 variant read left record intact");
    newInst();
    spec(7, 1, 1'b0);
    spec(2, 0, 1'b0);
    readChk(2, {8'h00, ent(2, 1)}, "R11 low immediate entry shifted out");
    newInst();
    spec(7, 1, 1'b0);
    readChk(2, 16'h0000, "R11 lone immediate entry erased");
    readChk(1, {8'h00, ent(7, 2)}, "R10 model 1 raw");
  endtask

  task automatic testIdleRead();
    newInst();
    spec(3, 1, 1'b1);
    modelSel = 2'd1;
    rdEn = 1'b0;
    #1;
    chk("R12 rdEn low reads zero", rdData, 16'h0000);
    readChk(1, {8'h00, ent(3, -2)}, "R12 same-cycle read value");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFormatAndPacking();
    testByteMode();
    testPcAndImmediate();
    testInstClearCollision();
    testTrap();
    testFreeze();
    testModels();
    testIdleRead();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule